// File: doc/BRIEF.md
# Pre/Post-Trigger Acquisition Sequencer

This block runs a single acquisition of a sampling instrument. Every sample enable is taken from one fast reference clock through a divider whose ratio is chosen for the selected time range. Once started, the sequencer first collects a programmed number of samples ahead of any trigger. Only then does it raise an arm line to the trigger logic. While it waits for the trigger, sampling carries on, so the ahead-of-trigger store keeps filling in a circular fashion.

A rising edge on the trigger input is synchronized, and it is accepted only while the arm line is high. It starts a countdown of a programmed number of after-trigger samples. When that countdown finishes, sample enables stop and a done flag is held for the host. The host clears the flag with an acknowledge, or starts the next acquisition at once.

The divider ratio and both sample counts are captured at start and held for the whole run. The state is visible on a small readout bus. All pins are plain control and status levels: nothing streams through the block, so there is no valid/ready handshake and no back-pressure to consider.

Top module: `acq_sequencer`

## Requirements
- R1: The readout `state_o` encodes 0 = idle, 1 = collecting ahead-of-trigger samples, 2 = armed, 3 = collecting after-trigger samples, 4 = done; a `start_i` pulse seen in idle moves the block into state 1, or straight into state 2 when the ahead-of-trigger count is 0, on the next clock edge and raises `busy_o`.
- R2: While busy with a divider value N, `sample_en_o` pulses once every N reference cycles with exactly N cycles between pulses; a value of 0 behaves as 1, and a value of 1 gives an enable on every busy cycle.
- R3: Exactly P sample enables occur in state 1, where P is the ahead-of-trigger count; `arm_o` rises on the clock edge that ends the P-th of them and stays high only in state 2.
- R4: Trigger activity before `arm_o` is high is ignored, and a trigger level already high when arming happens does not count; only a fresh rising edge is accepted.
- R5: A trigger rising edge driven between two clock edges leaves state 2 on the third clock edge after it (two synchronizer stages plus the edge register), and is accepted once.
- R6: After acceptance exactly Q sample enables occur in state 3, where Q is the after-trigger count, and the block enters done on the edge that ends the Q-th; with Q = 0 it goes from armed straight to done.
- R7: `sample_en_o` is low whenever `busy_o` is low, so enables stop at done.
- R8: `done_o` stays high until `ack_i` (back to idle) or `start_i` (new acquisition, with start taking precedence).
- R9: `start_i` while busy is ignored and does not reload the counts.
- R10: Divider value and both counts are sampled only when a start is accepted; changes on those inputs during a run have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse |
| ack_i | input | 1 | Host acknowledge of done |
| div_i | input | DIV_W | Sample divider ratio (0 acts as 1) |
| pre_cnt_i | input | CNT_W | Ahead-of-trigger sample count |
| post_cnt_i | input | CNT_W | After-trigger sample count |
| trig_i | input | 1 | Trigger-true from trigger logic, asynchronous |
| arm_o | output | 1 | Trigger logic may fire |
| sample_en_o | output | 1 | One-cycle sample enable |
| done_o | output | 1 | Acquisition complete |
| busy_o | output | 1 | Acquisition in progress |
| state_o | output | 3 | State readout |

## Verification
The properties assume that `trig_i` may change at any time, because only its synchronized edge is used. They also assume that `start_i` and `ack_i` are single-cycle host pulses, and that the configuration inputs matter only in the cycle in which a start is taken. The stimulus drives every input one nanosecond after a rising edge. It scrambles the configuration pins straight after each start and fires triggers both early and late. It keeps divider ratios and counts small, so that each run finishes well inside the wait limits. A trigger held high across arming, and starts issued while busy, are exercised on purpose because the properties must tolerate them.

// File: rtl/acq_pkg.sv
package acq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_PRE   = 3'd1,
    ST_ARMED = 3'd2,
    ST_POST  = 3'd3,
    ST_DONE  = 3'd4
  } acq_state_e;
endpackage

// File: rtl/acq_rate_div.sv
module acq_rate_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  localparam logic [DIV_W-1:0] ONE = {{(DIV_W-1){1'b0}}, 1'b1};

  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] div_eff;
  logic             last;

  assign div_eff = (div_i == '0) ? ONE : div_i;
  assign last    = (cnt == div_eff - ONE);
  assign tick_o  = run_i && last;

  always_ff @(posedge clk) begin
    if (!rst_n || !run_i) cnt <= '0;
    else if (last)        cnt <= '0;
    else                  cnt <= cnt + ONE;
  end
endmodule

// File: rtl/acq_trig_sync.sv
module acq_trig_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_i,
  output logic rise_o
);
  logic [SYNC_STAGES:0] sh;

  genvar g;
  generate
    for (g = 0; g <= SYNC_STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) sh[0] <= 1'b0;
          else        sh[0] <= trig_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) sh[g] <= 1'b0;
          else        sh[g] <= sh[g-1];
        end
      end
    end
  endgenerate

  assign rise_o = sh[SYNC_STAGES-1] && !sh[SYNC_STAGES];
endmodule

// File: rtl/acq_ctrl.sv
module acq_ctrl
  import acq_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             ack_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic [CNT_W-1:0] pre_i,
  input  logic [CNT_W-1:0] post_i,
  input  logic             tick_i,
  input  logic             trig_rise_i,
  output acq_state_e       state_o,
  output logic [DIV_W-1:0] div_q_o,
  output logic             run_o
);
  localparam logic [CNT_W-1:0] CONE = {{(CNT_W-1){1'b0}}, 1'b1};

  acq_state_e       state, state_n;
  logic [CNT_W-1:0] pre_rem, post_rem;
  logic             load;

  assign load = start_i && (state == ST_IDLE || state == ST_DONE);

  always_comb begin
    state_n = state;
    unique case (state)
      ST_IDLE, ST_DONE: begin
        if (load)                            state_n = (pre_i == '0) ? ST_ARMED : ST_PRE;
        else if (state == ST_DONE && ack_i)  state_n = ST_IDLE;
      end
      ST_PRE:   if (tick_i && pre_rem == CONE) state_n = ST_ARMED;
      ST_ARMED: if (trig_rise_i)               state_n = (post_rem == '0) ? ST_DONE : ST_POST;
      ST_POST:  if (tick_i && post_rem == CONE) state_n = ST_DONE;
      default:                                 state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      pre_rem  <= '0;
      post_rem <= '0;
      div_q_o  <= '0;
    end else begin
      state <= state_n;
      if (load) begin
        pre_rem  <= pre_i;
        post_rem <= post_i;
        div_q_o  <= div_i;
      end else begin
        if (state == ST_PRE && tick_i)  pre_rem  <= pre_rem - CONE;
        if (state == ST_POST && tick_i) post_rem <= post_rem - CONE;
      end
    end
  end

  assign state_o = state;
  assign run_o   = (state == ST_PRE) || (state == ST_ARMED) || (state == ST_POST);
endmodule

// File: rtl/acq_sequencer.sv
module acq_sequencer
  import acq_pkg::*;
#(
  parameter int DIV_W       = 8,
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             ack_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic [CNT_W-1:0] pre_cnt_i,
  input  logic [CNT_W-1:0] post_cnt_i,
  input  logic             trig_i,
  output logic             arm_o,
  output logic             sample_en_o,
  output logic             done_o,
  output logic             busy_o,
  output logic [2:0]       state_o
);
  acq_state_e       state;
  logic [DIV_W-1:0] div_q;
  logic             run;
  logic             tick;
  logic             trig_edge;

  acq_trig_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .rise_o(trig_edge)
  );

  acq_rate_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .run_i(run), .div_i(div_q), .tick_o(tick)
  );

  acq_ctrl #(.DIV_W(DIV_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .ack_i(ack_i),
    .div_i(div_i), .pre_i(pre_cnt_i), .post_i(post_cnt_i),
    .tick_i(tick), .trig_rise_i(trig_edge),
    .state_o(state), .div_q_o(div_q), .run_o(run)
  );

  assign arm_o       = (state == ST_ARMED);
  assign done_o      = (state == ST_DONE);
  assign busy_o      = run;
  assign sample_en_o = tick;
  assign state_o     = state;
endmodule

// File: rtl/acq_sequencer_chk.sv
module acq_sequencer_chk #(
  parameter int DIV_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             ack_i,
  input logic             trig_edge,
  input logic [DIV_W-1:0] div_q,
  input logic             arm_o,
  input logic             sample_en_o,
  input logic             done_o,
  input logic             busy_o,
  input logic [2:0]       state_o
);
  AST_START_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd0 && start_i) |=> (busy_o && (state_o == 3'd1 || state_o == 3'd2))); // R1

  AST_DIV_UNITY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && div_q <= 1) |-> sample_en_o); // R2

  AST_ARM_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_o && !trig_edge) |=> arm_o); // R4

  AST_DONE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> ($past(state_o) == 3'd2 || $past(state_o) == 3'd3)); // R6

  AST_EN_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    sample_en_o |-> busy_o); // R7

  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i && !ack_i) |=> done_o); // R8

  AST_START_IGNORED_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd3 && start_i && !sample_en_o) |=> state_o == 3'd3); // R9
endmodule

bind acq_sequencer acq_sequencer_chk #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .ack_i(ack_i),
  .trig_edge(trig_edge), .div_q(div_q), .arm_o(arm_o),
  .sample_en_o(sample_en_o), .done_o(done_o), .busy_o(busy_o), .state_o(state_o)
);

// File: tb/sim_acq_sequencer.sv
`timescale 1ns/1ps
module sim_acq_sequencer;
  localparam int DIV_W = 8;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, ack_i = 1'b0, trig_i = 1'b0;
  logic [DIV_W-1:0] div_i = '0;
  logic [CNT_W-1:0] pre_cnt_i = '0, post_cnt_i = '0;
  logic arm_o, sample_en_o, done_o, busy_o;
  logic [2:0] state_o;

  acq_sequencer #(.DIV_W(DIV_W), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .ack_i(ack_i), .div_i(div_i),
    .pre_cnt_i(pre_cnt_i), .post_cnt_i(post_cnt_i), .trig_i(trig_i),
    .arm_o(arm_o), .sample_en_o(sample_en_o), .done_o(done_o),
    .busy_o(busy_o), .state_o(state_o)
  );

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0;
  bit finished = 0;

  int pre_seen = 0, post_seen = 0, gap_bad = 0, since_en = 0, cur_div = 1;
  bit have_en = 0;

  always @(negedge clk) begin
    if (!busy_o) have_en = 0;
    if (sample_en_o) begin
      if (state_o == 3'd1) pre_seen++;
      if (state_o == 3'd3) post_seen++;
      if (have_en && since_en != cur_div) gap_bad++;
      have_en = 1;
      since_en = 1;
    end else begin
      since_en++;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  function automatic int eff_div(input int d);
    return (d == 0) ? 1 : d;
  endfunction

  function automatic int first_state(input int p);
    return (p == 0) ? 2 : 1;
  endfunction

  task automatic run_acq(input int dv, input int pre, input int post,
                         input bit early, input bit hold, input bit do_ack);
    int n;
    pre_seen = 0; post_seen = 0; gap_bad = 0; have_en = 0;
    cur_div = eff_div(dv);
    div_i = dv[DIV_W-1:0]; pre_cnt_i = pre[CNT_W-1:0]; post_cnt_i = post[CNT_W-1:0];
    if (hold) trig_i = 1'b1;
    start_i = 1'b1;
    step();
    start_i = 1'b0;
    chk("R1 busy after start", int'(busy_o), 1);
    chk("R1 state after start", int'(state_o), first_state(pre));
    // R10: scramble configuration during the run
    div_i = 8'd7; pre_cnt_i = 16'd3; post_cnt_i = 16'd5;
    if (early) begin
      trig_i = 1'b1; step(); step(); step(); trig_i = 1'b0;
      start_i = 1'b1; step(); start_i = 1'b0;   // R9 start while busy
      step(); step(); step();
      chk("R4 early trigger not armed", int'(arm_o), 0);
    end
    n = 0;
    while (!arm_o && n < 5000) begin step(); n++; end
    chk("R3 arm reached", int'(arm_o), 1);
    chk("R3 R9 R10 pre samples", pre_seen, pre);
    if (hold) begin
      for (int i = 0; i < 20; i++) step();
      chk("R4 held level not accepted", int'(state_o), 2);
      trig_i = 1'b0;
      step(); step(); step();
    end
    trig_i = 1'b1;
    step(); step();
    chk("R5 still armed two edges after trigger", int'(state_o), 2);
    step();
    chk("R5 left armed on third edge", int'(state_o), (post == 0) ? 4 : 3);
    step();
    trig_i = 1'b0;
    n = 0;
    while (!done_o && n < 5000) begin step(); n++; end
    chk("R6 done reached", int'(done_o), 1);
    chk("R6 R10 post samples", post_seen, post);
    chk("R2 R10 enable spacing errors", gap_bad, 0);
    step(); step(); step();
    chk("R7 no enable after done", int'(sample_en_o), 0);
    chk("R8 done held", int'(done_o), 1);
    chk("R7 not busy at done", int'(busy_o), 0);
    if (do_ack) begin
      ack_i = 1'b1; step(); ack_i = 1'b0;
      chk("R8 ack returns to idle", int'(state_o), 0);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    step(); step();
    rst_n = 1'b1;
    step();
    chk("R1 reset state", int'(state_o), 0);
    chk("R7 reset enable", int'(sample_en_o), 0);
    chk("R8 reset done", int'(done_o), 0);
    chk("R3 reset arm", int'(arm_o), 0);
    // directed corners
    run_acq(1, 0, 0, 0, 0, 1);   // R2 unity divider, R3 zero pre, R6 zero post
    run_acq(0, 3, 2, 0, 0, 1);   // R2 zero divider behaves as one
    run_acq(3, 8, 4, 1, 0, 0);   // R4 early trigger, R9 start while busy
    run_acq(2, 4, 3, 0, 1, 0);   // R4 held level, R8 restart from done
    run_acq(5, 2, 6, 0, 0, 1);
    // random runs
    for (int k = 0; k < 25; k++) begin
      run_acq(int'($urandom_range(0, 4)), int'($urandom_range(0, 10)),
              int'($urandom_range(0, 10)), 0, 0, bit'($urandom_range(0, 1)));
    end
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule